// File: doc/BRIEF.md
# Audio fade and mute level controller

This block sets the playback level of a stereo stream of signed samples. Each sample pair that arrives with a valid strobe comes out one clock later, multiplied by an internal level counter and divided by 128. A four-bit command code, qualified by a strobe, controls the level. Mute sends the level to zero. Attenuate sends it to 32, which is 12 dB down. Full scale sends it to 128, or to 120 when the downstream oversampling filter is enabled, which leaves 0.5 dB of headroom. Two further commands step the level up or down by one unit.

The mute, attenuate and full-scale commands do not jump. Each one sets a target, and the counter walks toward that target by one unit on every tick of a free-running prescaler. With the default prescaler of 1950 cycles, a full sweep of 128 units takes about 3 ms at an 84.7 MHz clock. A step command moves the counter at once, and the target moves with it, so the ramp does not pull the level back. A mute flag reports when the target is zero, so that an output kill stage downstream can be forced active.

Top module: `audio_level_ctrl`

## Requirements
- R1: One cycle after a sample cycle with `smp_valid` high, `out_valid` is high and each channel output equals input × level / 128, rounded toward zero. In every other cycle `out_valid` is low.
- R2: Command code x001 sets the target to 128 when `ovs_en` is low and to 120 when `ovs_en` is high, taking `ovs_en` from the command cycle.
- R3: Command codes x010 and x011 set the target to 32.
- R4: Command code x000 sets the target to 0. `mute_active` is high exactly while the target is 0, starting the cycle after the command. After reset the level and the target are 0, `mute_active` is high and the outputs are 0.
- R5: A prescaler runs freely from reset and ticks once every TICK_CYCLES cycles, first in the TICK_CYCLES-th cycle after reset. On a tick, the level moves one unit toward the target. Between ticks the level holds unless a step command arrives.
- R6: Command code x101 raises the level by 1 at the next edge, and the target follows the new level. If the level is already at or above the current full-scale value (128, or 120 with `ovs_en` high), the level does not change. A step command in a tick cycle takes the place of that tick's ramp move.
- R7: Command code x100 lowers the level by 1 at the next edge, and the target follows the new level. A level of 0 stays at 0.
- R8: Bit 3 of the command code is ignored. Codes x110 and x111 have no effect on the level or the target.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmd_valid | input | 1 | Command strobe |
| cmd_code | input | 4 | Command code; bits 2:0 select the operation |
| ovs_en | input | 1 | Oversampling enabled, selects the 120 full-scale value |
| smp_valid | input | 1 | Input sample pair valid |
| smp_left | input | 16 | Left input sample, signed |
| smp_right | input | 16 | Right input sample, signed |
| out_valid | output | 1 | Output sample pair valid |
| out_left | output | 16 | Scaled left sample, signed |
| out_right | output | 16 | Scaled right sample, signed |
| mute_active | output | 1 | High while the level target is zero |

## Verification
The bench feeds a pseudo-random sample stream with gaps, and mixes in the extreme values -32768, 32767, -1 and +1. This stream runs while the level is ramping, so truncation toward zero on negative products shows up separately from plain arithmetic shifting, and the level in use at each sample edge is exposed. Probe samples of +16384 and -16384 are sent at settled levels. These turn the hidden level into an exact output value (level × 128), which tells apart unity gain, the 120 and 32 targets, saturation and the zero floor. Step commands, codes with bit 3 set and reserved codes are applied at settled levels, where any wrong level or target change shows up in the probe outputs.

// File: rtl/alc_pkg.sv
package alc_pkg;

    typedef enum logic [2:0] {
        OP_NONE  = 3'd0,
        OP_MUTE  = 3'd1,
        OP_ATTEN = 3'd2,
        OP_FULL  = 3'd3,
        OP_DOWN  = 3'd4,
        OP_UP    = 3'd5
    } alc_op_e;

endpackage

// File: rtl/alc_cmd_decode.sv
module alc_cmd_decode #(
    parameter int CODE_W = 4
) (
    input  logic                cmd_valid,
    input  logic [CODE_W-1:0]   cmd_code,
    output alc_pkg::alc_op_e    op
);
    import alc_pkg::*;

    // Only the low three bits select an operation; upper bits carry no meaning.
    logic [CODE_W-4:0] code_unused;
    assign code_unused = cmd_code[CODE_W-1:3];

    always_comb begin
        op = OP_NONE;
        if (cmd_valid) begin
            case (cmd_code[2:0])
                3'b000:         op = OP_MUTE;
                3'b001:         op = OP_FULL;
                3'b010, 3'b011: op = OP_ATTEN;
                3'b100:         op = OP_DOWN;
                3'b101:         op = OP_UP;
                default:        op = OP_NONE;
            endcase
        end
    end

endmodule

// File: rtl/alc_level_ramp.sv
module alc_level_ramp #(
    parameter int LEVEL_W     = 8,
    parameter int FULL_LVL    = 128,
    parameter int OVS_LVL     = 120,
    parameter int ATT_LVL     = 32,
    parameter int TICK_CYCLES = 1950
) (
    input  logic                clk,
    input  logic                rst_n,
    input  alc_pkg::alc_op_e    op,
    input  logic                ovs_en,
    output logic [LEVEL_W-1:0]  level_q,
    output logic                mute_active
);
    import alc_pkg::*;

    localparam int TICK_W = (TICK_CYCLES > 1) ? $clog2(TICK_CYCLES) : 1;
    localparam logic [TICK_W-1:0]  TICK_LAST = TICK_W'(TICK_CYCLES - 1);
    localparam logic [LEVEL_W-1:0] FULL_L    = LEVEL_W'(FULL_LVL);
    localparam logic [LEVEL_W-1:0] OVS_L     = LEVEL_W'(OVS_LVL);
    localparam logic [LEVEL_W-1:0] ATT_L     = LEVEL_W'(ATT_LVL);
    localparam logic [LEVEL_W-1:0] ONE_L     = LEVEL_W'(1);

    typedef struct packed {
        logic [LEVEL_W-1:0] level;
        logic [LEVEL_W-1:0] target;
        logic [TICK_W-1:0]  pre;
    } ramp_t;

    ramp_t               st_q, st_d;
    logic                tick;
    logic                is_step;
    logic [LEVEL_W-1:0]  full_now;
    logic [LEVEL_W-1:0]  step_lvl;

    always_comb begin
        st_d     = st_q;
        tick     = (st_q.pre == TICK_LAST);
        is_step  = (op == OP_UP) || (op == OP_DOWN);
        full_now = ovs_en ? OVS_L : FULL_L;
        step_lvl = st_q.level;

        st_d.pre = tick ? '0 : st_q.pre + TICK_W'(1);

        if (tick && !is_step) begin
            if (st_q.level < st_q.target)
                st_d.level = st_q.level + ONE_L;
            else if (st_q.level > st_q.target)
                st_d.level = st_q.level - ONE_L;
        end

        case (op)
            OP_MUTE:  st_d.target = '0;
            OP_ATTEN: st_d.target = ATT_L;
            OP_FULL:  st_d.target = full_now;
            OP_DOWN: begin
                if (st_q.level != '0)
                    step_lvl = st_q.level - ONE_L;
                st_d.level  = step_lvl;
                st_d.target = step_lvl;
            end
            OP_UP: begin
                if (st_q.level < full_now)
                    step_lvl = st_q.level + ONE_L;
                st_d.level  = step_lvl;
                st_d.target = step_lvl;
            end
            default: ;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign level_q     = st_q.level;
    assign mute_active = (st_q.target == '0);

    AST_LEVEL_CEIL: assert property (@(posedge clk) disable iff (!rst_n)
        level_q <= FULL_L);  // R6

    AST_RAMP_UNIT: assert property (@(posedge clk) disable iff (!rst_n)
        (op != OP_UP && op != OP_DOWN) |=>
            (level_q == $past(level_q) || level_q == $past(level_q) + ONE_L
             || level_q == $past(level_q) - ONE_L));  // R5

    AST_HOLD_NO_TICK: assert property (@(posedge clk) disable iff (!rst_n)
        (!tick && op != OP_UP && op != OP_DOWN) |=> $stable(level_q));  // R5

    AST_FLOOR_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        (op == OP_DOWN && level_q == '0) |=> (level_q == '0));  // R7

    AST_MUTE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
        (mute_active && level_q == '0 && op != OP_UP && op != OP_FULL
         && op != OP_ATTEN) |=> (level_q == '0));  // R4

endmodule

// File: rtl/alc_scaler.sv
module alc_scaler #(
    parameter int SAMPLE_W = 16,
    parameter int LEVEL_W  = 8,
    parameter int SHIFT    = 7,
    parameter int CHANNELS = 2
) (
    input  logic                         clk,
    input  logic                         rst_n,
    input  logic                         in_valid,
    input  logic [CHANNELS*SAMPLE_W-1:0] in_data,
    input  logic [LEVEL_W-1:0]           level,
    output logic                         out_valid,
    output logic [CHANNELS*SAMPLE_W-1:0] out_data
);
    localparam int PROD_W = SAMPLE_W + LEVEL_W + 1;
    localparam logic signed [PROD_W-1:0] BIAS  = PROD_W'((1 << SHIFT) - 1);
    localparam logic [LEVEL_W-1:0]       UNITY = LEVEL_W'(1 << SHIFT);

    typedef struct packed {
        logic                         valid;
        logic [CHANNELS*SAMPLE_W-1:0] data;
    } scl_t;

    scl_t                         sc_q, sc_d;
    logic [CHANNELS*SAMPLE_W-1:0] scaled;

    for (genvar c = 0; c < CHANNELS; c++) begin : g_chan
        logic signed [PROD_W-1:0] prod;
        logic signed [PROD_W-1:0] biased;
        always_comb begin
            prod   = PROD_W'($signed(in_data[c*SAMPLE_W +: SAMPLE_W]))
                   * PROD_W'($signed({1'b0, level}));
            // negative products get a bias so the shift truncates toward zero
            biased = prod[PROD_W-1] ? prod + BIAS : prod;
        end
        assign scaled[c*SAMPLE_W +: SAMPLE_W] = SAMPLE_W'(biased >>> SHIFT);
    end

    always_comb begin
        sc_d       = sc_q;
        sc_d.valid = in_valid;
        if (in_valid)
            sc_d.data = scaled;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) sc_q <= '0;
        else        sc_q <= sc_d;
    end

    assign out_valid = sc_q.valid;
    assign out_data  = sc_q.data;

    AST_ZERO_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && level == '0) |=> (out_data == '0));  // R1

    AST_UNITY_GAIN: assert property (@(posedge clk) disable iff (!rst_n)
        (in_valid && level == UNITY) |=> (out_data == $past(in_data)));  // R1

endmodule

// File: rtl/audio_level_ctrl.sv
module audio_level_ctrl #(
    parameter int SAMPLE_W    = 16,
    parameter int LEVEL_W     = 8,
    parameter int CODE_W      = 4,
    parameter int FULL_LVL    = 128,
    parameter int OVS_LVL     = 120,
    parameter int ATT_LVL     = 32,
    parameter int TICK_CYCLES = 1950
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                cmd_valid,
    input  logic [CODE_W-1:0]   cmd_code,
    input  logic                ovs_en,
    input  logic                smp_valid,
    input  logic [SAMPLE_W-1:0] smp_left,
    input  logic [SAMPLE_W-1:0] smp_right,
    output logic                out_valid,
    output logic [SAMPLE_W-1:0] out_left,
    output logic [SAMPLE_W-1:0] out_right,
    output logic                mute_active
);
    localparam int SHIFT = $clog2(FULL_LVL);

    alc_pkg::alc_op_e    op;
    logic [LEVEL_W-1:0]  level;
    logic [2*SAMPLE_W-1:0] scaled_pair;

    alc_cmd_decode #(.CODE_W(CODE_W)) u_dec (
        .cmd_valid (cmd_valid),
        .cmd_code  (cmd_code),
        .op        (op)
    );

    alc_level_ramp #(
        .LEVEL_W     (LEVEL_W),
        .FULL_LVL    (FULL_LVL),
        .OVS_LVL     (OVS_LVL),
        .ATT_LVL     (ATT_LVL),
        .TICK_CYCLES (TICK_CYCLES)
    ) u_ramp (
        .clk         (clk),
        .rst_n       (rst_n),
        .op          (op),
        .ovs_en      (ovs_en),
        .level_q     (level),
        .mute_active (mute_active)
    );

    alc_scaler #(
        .SAMPLE_W (SAMPLE_W),
        .LEVEL_W  (LEVEL_W),
        .SHIFT    (SHIFT),
        .CHANNELS (2)
    ) u_scale (
        .clk       (clk),
        .rst_n     (rst_n),
        .in_valid  (smp_valid),
        .in_data   ({smp_right, smp_left}),
        .level     (level),
        .out_valid (out_valid),
        .out_data  (scaled_pair)
    );

    assign out_left  = scaled_pair[SAMPLE_W-1:0];
    assign out_right = scaled_pair[2*SAMPLE_W-1:SAMPLE_W];

endmodule

// File: tb/sim_audio_level_ctrl.sv
module sim_audio_level_ctrl;

    localparam int T = 4;

    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        cmd_valid = 1'b0;
    logic [3:0]  cmd_code = 4'd0;
    logic        ovs_en = 1'b0;
    logic        smp_valid = 1'b0;
    logic [15:0] smp_left = 16'd0;
    logic [15:0] smp_right = 16'd0;
    logic        out_valid;
    logic [15:0] out_left;
    logic [15:0] out_right;
    logic        mute_active;

    int checks = 0;
    int errors = 0;
    bit done = 1'b0;
    int cyc = 0;

    // reference model state
    int m_lvl = 0, m_tgt = 0, m_pre = 0;
    int m_ol = 0, m_or = 0;
    bit m_ov = 1'b0;
    logic [15:0] lfsr = 16'hACE1;

    always #2 clk = ~clk;

    audio_level_ctrl #(.TICK_CYCLES(T)) u0 (
        .clk(clk), .rst_n(rst_n), .cmd_valid(cmd_valid), .cmd_code(cmd_code),
        .ovs_en(ovs_en), .smp_valid(smp_valid), .smp_left(smp_left),
        .smp_right(smp_right), .out_valid(out_valid), .out_left(out_left),
        .out_right(out_right), .mute_active(mute_active)
    );

    task automatic chk(input bit ok, input string req, input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0d expected=%0d", req, act, exp);
        end
    endtask

    task automatic summary();
        $display("Result: errors=%0d of %0d checks", errors, checks);
    endtask

    // behavioural reference, one update per rising edge
    always @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            m_lvl = 0; m_tgt = 0; m_pre = 0; m_ol = 0; m_or = 0; m_ov = 0;
        end else begin
            int full;
            int old_tgt;
            bit tick;
            bit step;
            full    = ovs_en ? 120 : 128;
            tick    = (m_pre == T - 1);
            old_tgt = m_tgt;
            step    = cmd_valid && (cmd_code[2:0] == 3'b100 || cmd_code[2:0] == 3'b101);
            m_ov = smp_valid;
            if (smp_valid) begin
                m_ol = (int'($signed(smp_left))  * m_lvl) / 128;
                m_or = (int'($signed(smp_right)) * m_lvl) / 128;
            end
            if (tick && !step) begin
                if (m_lvl < old_tgt) m_lvl++;
                else if (m_lvl > old_tgt) m_lvl--;
            end
            if (cmd_valid) begin
                case (cmd_code[2:0])
                    3'b000: m_tgt = 0;
                    3'b001: m_tgt = full;
                    3'b010, 3'b011: m_tgt = 32;
                    3'b100: begin if (m_lvl > 0) m_lvl--; m_tgt = m_lvl; end
                    3'b101: begin if (m_lvl < full) m_lvl++; m_tgt = m_lvl; end
                    default: ;
                endcase
            end
            m_pre = tick ? 0 : m_pre + 1;
        end
    end

    // cycle compare away from the active edge
    always @(negedge clk) begin
        if (rst_n && !done) begin
            chk(out_valid == m_ov, "R1 out_valid", int'(out_valid), int'(m_ov));
            if (m_ov) begin
                chk(int'($signed(out_left)) == m_ol, "R1 out_left",
                    int'($signed(out_left)), m_ol);
                chk(int'($signed(out_right)) == m_or, "R1 out_right",
                    int'($signed(out_right)), m_or);
            end
            chk(mute_active == (m_tgt == 0), "R4 mute_active",
                int'(mute_active), int'(m_tgt == 0));
        end
    end

    always @(posedge clk) begin
        cyc++;
        if (cyc > 100000 && !done) begin
            done = 1'b1;
            checks++; errors++;
            $display("FAIL watchdog actual=%0d expected=%0d", cyc, 100000);
            summary();
            $finish;
        end
    end

    task automatic run(input int n);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
            smp_valid = lfsr[0] | lfsr[3];
            case (k % 8)
                0: begin smp_left = 16'h8000; smp_right = 16'h7FFF; end
                1: begin smp_left = 16'hFFFF; smp_right = 16'h0001; end
                default: begin smp_left = lfsr; smp_right = ~lfsr ^ 16'h5A5A; end
            endcase
        end
        @(negedge clk);
        smp_valid = 1'b0;
    endtask

    task automatic cmd(input logic [3:0] c);
        @(negedge clk);
        smp_valid = 1'b0;
        cmd_valid = 1'b1;
        cmd_code  = c;
        @(negedge clk);
        cmd_valid = 1'b0;
    endtask

    // settled-level probe: +/-16384 in gives +/-level*128 out
    task automatic probe(input int exp, input string req);
        @(negedge clk);
        smp_valid = 1'b1;
        smp_left  = 16'd16384;
        smp_right = 16'hC000;
        @(negedge clk);
        smp_valid = 1'b0;
        chk(int'($signed(out_left)) == exp * 128, req, int'($signed(out_left)) / 128, exp);
        chk(int'($signed(out_right)) == -exp * 128, req, -int'($signed(out_right)) / 128, exp);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        // R4 reset state
        chk(mute_active == 1'b1, "R4 reset mute", int'(mute_active), 1);
        chk(out_valid == 1'b0, "R4 reset valid", int'(out_valid), 0);
        chk(out_left == 16'd0, "R4 reset out", int'(out_left), 0);
        rst_n = 1'b1;
        probe(0, "R4 level 0 after reset");

        cmd(4'b0001);                          // R2 full scale, no oversampling
        chk(mute_active == 1'b0, "R4 mute released", int'(mute_active), 0);
        run(560);                              // R5 ramp under random stream
        probe(128, "R2 full scale 128");

        cmd(4'b0011);                          // R3 attenuate
        run(450);
        probe(32, "R3 attenuate 32");

        cmd(4'b0101);                          // R6 immediate step up
        probe(33, "R6 step up");
        cmd(4'b0101);
        cmd(4'b0101);
        run(20);
        probe(35, "R6 step target follows");

        for (int i = 0; i < 40; i++) cmd(4'b0100);   // R7 floor
        probe(0, "R7 step down floor");
        chk(mute_active == 1'b1, "R7 target zero", int'(mute_active), 1);

        ovs_en = 1'b1;
        cmd(4'b1001);                          // R2 with oversampling, R8 bit 3
        run(540);
        probe(120, "R2 oversampling 120 / R8 bit3");
        cmd(4'b0101);
        run(10);
        probe(120, "R6 saturation at 120");

        cmd(4'b0110);                          // R8 reserved codes
        cmd(4'b0111);
        cmd(4'b1111);
        run(30);
        probe(120, "R8 reserved no effect");
        chk(mute_active == 1'b0, "R8 reserved mute", int'(mute_active), 0);

        cmd(4'b1000);                          // R4 mute with bit 3 set
        chk(mute_active == 1'b1, "R4 mute immediate", int'(mute_active), 1);
        run(500);
        probe(0, "R4 muted level");

        done = 1'b1;
        summary();
        $finish;
    end

endmodule